// File: doc/BRIEF.md
# Video Frame Memory SDRAM Controller

This block connects one internal requester to a single x16 SDRAM that holds video frames. After reset it waits for a set number of clocks. It then brings the device up with a fixed command sequence and raises `ready_o`. From then on it serves read and write requests as two-beat sequential bursts.

Each burst opens its row and issues the column command with automatic precharge. It then holds off the next command until the device has closed the bank again. The command gaps are whole clock counts chosen for a memory clock near 81 MHz with CAS latency 2.

A refresh timer raises a pending flag at a fixed interval. The sequencer serves that flag at the next idle point, ahead of any waiting client request. It never breaks into a running burst.

The client raises `req_i` and keeps the address, write flag, data and masks stable until `done_o` pulses. It may present the next request in the same cycle that `done_o` is seen.

Top module: `vsdram_ctrl`

## Requirements
- R1: After reset release, no command other than NOP appears for at least INIT_CYCLES clocks. The controller then issues PRECHARGE with address bit 10 set (all banks), two AUTO REFRESH, and MODE REGISTER SET with address 0x021. In that address, bits 2:0 = 001 select burst length 2, bit 3 = 0 selects sequential wrap, bits 6:4 = 010 select CAS latency 2, and bit 9 = 0 selects burst writes. `ready_o` is low until that load is done and stays high afterwards.
- R2: Commands are encoded on {cs, ras, cas, we} (all active low) as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001 and MODE REGISTER SET 0000. A request raised before `ready_o` produces no ACTIVE, READ or WRITE until the device is initialised. While in reset, the command is NOP and `ready_o`, `done_o`, `rvalid_o` and `sd_dq_oe_o` are low.
- R3: The required spacing from a command to the next non-NOP command is PRECHARGE 2, AUTO REFRESH 6 and MODE REGISTER SET 4. ACTIVE is followed by READ/WRITE exactly 2 clocks later. Two ACTIVE commands are at least 6 clocks apart.
- R4: ACTIVE carries the request bank on `sd_ba_o` and the row on `sd_a_o`. READ and WRITE carry the column on `sd_a_o[8:0]` with `sd_a_o[10]` high, which requests automatic precharge.
- R5: A write drives beat 0 (`wdata_i[15:0]`) in the WRITE cycle and beat 1 (`wdata_i[31:16]`) in the next cycle, with `sd_dq_oe_o` high in both. The masks go out on `sd_dqm_o`: `wmask_i[1:0]` with beat 0 and `wmask_i[3:2]` with beat 1. Mask bit 1 (active high) blocks data bits 15:8 and mask bit 0 blocks bits 7:0.
- R6: After a WRITE, the next command comes at least 5 clocks later (4 after the last data). `done_o` is a one-cycle pulse, 3 clocks after the WRITE.
- R7: For a read, `sd_dq_i` is sampled 2 and 3 clocks after READ. The two words come out on `rdata_o` with `rvalid_o` high in two consecutive cycles, beat 0 first. `done_o` pulses with the second beat. The next command is at least 6 clocks after READ. A write burst produces no `rvalid_o`.
- R8: After initialisation, AUTO REFRESH repeats at least once every REF_INTERVAL+16 clocks, both while idle and under continuous traffic. It never falls inside a burst.
- R9: Burst order follows the device's sequential wrap. Starting at an odd column, beat 1 goes to the even column of the same pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst request, held until done_o |
| we_i | input | 1 | 1 = write burst, 0 = read burst |
| bank_i | input | 2 | Bank address |
| row_i | input | 13 | Row address |
| col_i | input | 9 | Starting column |
| wdata_i | input | 32 | Write data, beat 1 in [31:16], beat 0 in [15:0] |
| wmask_i | input | 4 | Byte masks, beat 1 in [3:2], beat 0 in [1:0], bit 1 = upper byte |
| ready_o | output | 1 | Initialisation complete |
| done_o | output | 1 | One-cycle burst completion pulse |
| rdata_o | output | 16 | Read data beat |
| rvalid_o | output | 1 | rdata_o holds a beat |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank select |
| sd_a_o | output | 13 | Row / column / mode address |
| sd_dq_o | output | 16 | Write data to the memory |
| sd_dq_oe_o | output | 1 | Drive enable for sd_dq_o |
| sd_dqm_o | output | 2 | Byte masks, bit 1 upper, active high |
| sd_dq_i | input | 16 | Read data from the memory |

## Verification
The bench runs bursts that differ in bank, row and starting column. It writes to two banks and reads back, which shows whether bank and row reach the pins. A write with one byte masked in each beat is read back to check that each mask gates its own byte and its own beat. A burst that starts at an odd column separates the beat order and column wrap from a plain increment. A behavioural memory model checks every command gap and the initialisation order. After the traffic, a long idle window confirms that refresh keeps running without requests.

// File: rtl/vsdram_pkg.sv
package vsdram_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_PWR, S_PRE_ALL, S_REF_A, S_REF_B, S_MRS, S_WAIT, S_IDLE, S_RW
  } seq_state_e;
endpackage

// File: rtl/vsdram_ref_timer.sv
module vsdram_ref_timer #(
  parameter int REF_INTERVAL = 620
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int RCW = $clog2(REF_INTERVAL + 1);
  logic [RCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (ack_i) pend_o <= 1'b0;
      if (en_i) begin
        if (cnt_q == RCW'(REF_INTERVAL - 1)) begin
          cnt_q  <= '0;
          pend_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vsdram_rd_capture.sv
module vsdram_rd_capture #(
  parameter int DW = 16,
  parameter int CL = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_cmd_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  // rd_sh[k] set means a READ went out k+1 cycles ago
  logic [CL:0] rd_sh;
  logic        take;

  assign take = rd_sh[CL-1] | rd_sh[CL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sh    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rd_sh    <= {rd_sh[CL-1:0], rd_cmd_i};
      rvalid_o <= take;
      if (take) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/vsdram_cmd_seq.sv
module vsdram_cmd_seq
  import vsdram_pkg::*;
#(
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int BA_W        = 2,
  parameter int DW          = 16,
  parameter int CL          = 2,
  parameter int INIT_CYCLES = 16200,
  parameter int T_RP        = 2,
  parameter int T_RC        = 6,
  parameter int T_RCD       = 2,
  parameter int T_MRD       = 4,
  parameter int WR_GAP      = 5,
  parameter int RD_GAP      = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [BA_W-1:0] bank_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2*DW-1:0] wdata_i,
  input  logic [3:0]      wmask_i,
  input  logic            ref_pend_i,
  output logic            ref_ack_o,
  output logic            ready_o,
  output logic            done_o,
  output logic            rd_cmd_o,
  output logic [3:0]      cmd_o,
  output logic [BA_W-1:0] ba_o,
  output logic [ROW_W-1:0] a_o,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe_o,
  output logic [1:0]      dqm_o
);
  localparam int ICW  = $clog2(INIT_CYCLES + 1);
  localparam int MAXG = T_RC + T_MRD + T_RP + T_RCD + WR_GAP + RD_GAP;
  localparam int WCW  = $clog2(MAXG + 1);
  localparam logic [ROW_W-1:0] A10_BIT   = ROW_W'(1024);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((CL << 4) | 1);

  seq_state_e       state_q, nxt_q;
  logic [WCW-1:0]   wcnt_q;
  logic [ICW-1:0]   icnt_q;
  sd_cmd_e          cmd_q;
  logic             ready_q, burst_q, we_q, wr_ph_q;
  logic [COL_W-1:0] col_q;
  logic [2*DW-1:0]  wdata_q;
  logic [3:0]       wmask_q;
  logic [ROW_W-1:0] rw_addr;

  always_comb begin
    rw_addr = A10_BIT;
    rw_addr[COL_W-1:0] = col_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PWR;
      nxt_q   <= S_IDLE;
      wcnt_q  <= '0;
      icnt_q  <= '0;
      cmd_q   <= CMD_NOP;
      ba_o    <= '0;
      a_o     <= '0;
      ready_q <= 1'b0;
      burst_q <= 1'b0;
      we_q    <= 1'b0;
      col_q   <= '0;
      wdata_q <= '0;
      wmask_q <= '0;
      wr_ph_q <= 1'b0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      dqm_o   <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      // second write beat follows the WRITE cycle
      if (wr_ph_q) begin
        dq_o    <= wdata_q[2*DW-1:DW];
        dqm_o   <= wmask_q[3:2];
        wr_ph_q <= 1'b0;
      end else begin
        dq_oe_o <= 1'b0;
        dqm_o   <= '0;
      end
      unique case (state_q)
        S_PWR: begin
          if (icnt_q == ICW'(INIT_CYCLES - 1)) state_q <= S_PRE_ALL;
          else icnt_q <= icnt_q + 1'b1;
        end
        S_PRE_ALL: begin
          cmd_q <= CMD_PRE; a_o <= A10_BIT;
          state_q <= S_WAIT; nxt_q <= S_REF_A; wcnt_q <= WCW'(T_RP - 2);
        end
        S_REF_A: begin
          cmd_q <= CMD_REF;
          state_q <= S_WAIT; nxt_q <= S_REF_B; wcnt_q <= WCW'(T_RC - 2);
        end
        S_REF_B: begin
          cmd_q <= CMD_REF;
          state_q <= S_WAIT; nxt_q <= S_MRS; wcnt_q <= WCW'(T_RC - 2);
        end
        S_MRS: begin
          cmd_q <= CMD_MRS; a_o <= MODE_WORD; ba_o <= '0;
          state_q <= S_WAIT; nxt_q <= S_IDLE; wcnt_q <= WCW'(T_MRD - 2);
        end
        S_WAIT: begin
          if (wcnt_q == '0) begin
            state_q <= nxt_q;
            if (nxt_q == S_IDLE) ready_q <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        S_IDLE: begin
          if (ref_pend_i) begin
            cmd_q <= CMD_REF; burst_q <= 1'b0;
            state_q <= S_WAIT; nxt_q <= S_IDLE; wcnt_q <= WCW'(T_RC - 2);
          end else if (req_i) begin
            cmd_q   <= CMD_ACT;
            ba_o    <= bank_i;
            a_o     <= row_i;
            we_q    <= we_i;
            col_q   <= col_i;
            wdata_q <= wdata_i;
            wmask_q <= wmask_i;
            burst_q <= 1'b1;
            state_q <= S_WAIT; nxt_q <= S_RW; wcnt_q <= WCW'(T_RCD - 2);
          end
        end
        S_RW: begin
          a_o <= rw_addr;
          state_q <= S_WAIT; nxt_q <= S_IDLE;
          if (we_q) begin
            cmd_q   <= CMD_WR;
            dq_o    <= wdata_q[DW-1:0];
            dqm_o   <= wmask_q[1:0];
            dq_oe_o <= 1'b1;
            wr_ph_q <= 1'b1;
            wcnt_q  <= WCW'(WR_GAP - 2);
          end else begin
            cmd_q  <= CMD_RD;
            wcnt_q <= WCW'(RD_GAP - 2);
          end
        end
        default: state_q <= S_PWR;
      endcase
    end
  end

  assign cmd_o     = cmd_q;
  assign ready_o   = ready_q;
  assign rd_cmd_o  = (cmd_q == CMD_RD);
  assign ref_ack_o = (state_q == S_IDLE) && ref_pend_i;
  assign done_o    = (state_q == S_WAIT) && (wcnt_q == '0) && (nxt_q == S_IDLE) && burst_q;
endmodule

// File: rtl/vsdram_ctrl.sv
module vsdram_ctrl #(
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int BA_W         = 2,
  parameter int DW           = 16,
  parameter int CL           = 2,
  parameter int INIT_CYCLES  = 16200,
  parameter int REF_INTERVAL = 620,
  parameter int T_RP         = 2,
  parameter int T_RC         = 6,
  parameter int T_RCD        = 2,
  parameter int T_DAL        = 4,
  parameter int T_MRD        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2*DW-1:0]  wdata_i,
  input  logic [3:0]       wmask_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             sd_cs_no,
  output logic             sd_ras_no,
  output logic             sd_cas_no,
  output logic             sd_we_no,
  output logic [BA_W-1:0]  sd_ba_o,
  output logic [ROW_W-1:0] sd_a_o,
  output logic [DW-1:0]    sd_dq_o,
  output logic             sd_dq_oe_o,
  output logic [1:0]       sd_dqm_o,
  input  logic [DW-1:0]    sd_dq_i
);
  localparam int BL      = 2;
  localparam int WR_A    = T_DAL + BL - 1;
  localparam int WR_B    = T_RC - T_RCD;
  localparam int WR_GAP  = (WR_A > WR_B) ? WR_A : WR_B;
  // read waits for its last beat to be handed out
  localparam int RD_A    = CL + BL + 2;
  localparam int RD_B    = BL + T_RP;
  localparam int RD_AB   = (RD_A > RD_B) ? RD_A : RD_B;
  localparam int RD_GAP  = (RD_AB > WR_B) ? RD_AB : WR_B;

  logic       ref_pend, ref_ack, rd_cmd;
  logic [3:0] cmd;

  vsdram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ready_o), .ack_i(ref_ack), .pend_o(ref_pend)
  );

  vsdram_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W), .DW(DW), .CL(CL),
    .INIT_CYCLES(INIT_CYCLES), .T_RP(T_RP), .T_RC(T_RC), .T_RCD(T_RCD),
    .T_MRD(T_MRD), .WR_GAP(WR_GAP), .RD_GAP(RD_GAP)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .bank_i(bank_i), .row_i(row_i), .col_i(col_i), .wdata_i(wdata_i), .wmask_i(wmask_i),
    .ref_pend_i(ref_pend), .ref_ack_o(ref_ack), .ready_o(ready_o), .done_o(done_o),
    .rd_cmd_o(rd_cmd), .cmd_o(cmd), .ba_o(sd_ba_o), .a_o(sd_a_o),
    .dq_o(sd_dq_o), .dq_oe_o(sd_dq_oe_o), .dqm_o(sd_dqm_o)
  );

  vsdram_rd_capture #(.DW(DW), .CL(CL)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_cmd_i(rd_cmd), .dq_i(sd_dq_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd;
endmodule

// File: rtl/vsdram_ctrl_chk.sv
module vsdram_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic done_o,
  input logic rvalid_o,
  input logic sd_cs_no,
  input logic sd_ras_no,
  input logic sd_cas_no,
  input logic sd_we_no,
  input logic a10_i,
  input logic sd_dq_oe_o
);
  logic [3:0] cmd;
  logic [3:0] since_act;
  logic is_act, is_rd, is_wr, is_nop;

  assign cmd    = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};
  assign is_act = (cmd == 4'b0011);
  assign is_rd  = (cmd == 4'b0101);
  assign is_wr  = (cmd == 4'b0100);
  assign is_nop = (cmd == 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_act <= 4'hf;
    else if (is_act) since_act <= '0;
    else if (since_act != 4'hf) since_act <= since_act + 1'b1;
  end

  // R2
  no_client_cmd_before_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !(is_act || is_rd || is_wr));
  // R3
  act_then_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |=> is_nop);
  // R3
  act_to_act_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> since_act >= 4'd5);
  // R4
  rw_auto_precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd || is_wr) |-> a10_i);
  // R5
  write_beats_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |-> sd_dq_oe_o ##1 sd_dq_oe_o);
  // R6
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  rvalid_pair_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |=> rvalid_o);
  // R7
  rvalid_pair_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rvalid_o)) |=> !rvalid_o);
endmodule

bind vsdram_ctrl vsdram_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .done_o(done_o),
  .rvalid_o(rvalid_o), .sd_cs_no(sd_cs_no), .sd_ras_no(sd_ras_no),
  .sd_cas_no(sd_cas_no), .sd_we_no(sd_we_no), .a10_i(sd_a_o[10]),
  .sd_dq_oe_o(sd_dq_oe_o)
);

// File: tb/vsdram_ctrl_bench.sv
module vsdram_ctrl_bench;
  localparam int INIT_CYC = 40;
  localparam int REF_INT  = 150;
  localparam int VW = 77;
  // {we, bank[2], row[3], col[3], wdata[32], mask[4], expected[32]}
  localparam logic [VW-1:0] VEC [8] = '{
    {1'b1, 2'd0, 3'd1, 3'd2, 32'h5678_1234, 4'h0, 32'h0},
    {1'b1, 2'd3, 3'd5, 3'd4, 32'h9ABC_DEF0, 4'h0, 32'h0},
    {1'b0, 2'd0, 3'd1, 3'd2, 32'h0,         4'h0, 32'h5678_1234},
    {1'b0, 2'd3, 3'd5, 3'd4, 32'h0,         4'h0, 32'h9ABC_DEF0},
    {1'b1, 2'd0, 3'd1, 3'd2, 32'hAAAA_BBBB, 4'h6, 32'h0},
    {1'b0, 2'd0, 3'd1, 3'd2, 32'h0,         4'h0, 32'hAA78_12BB},
    {1'b1, 2'd2, 3'd7, 3'd7, 32'h0F0F_F0F0, 4'h0, 32'h0},
    {1'b0, 2'd2, 3'd7, 3'd6, 32'h0,         4'h0, 32'hF0F0_0F0F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] bank = '0;
  logic [12:0] row = '0;
  logic [8:0] col = '0;
  logic [31:0] wdata = '0;
  logic [3:0] wmask = '0;
  logic ready, done, rvalid, cs_n, ras_n, cas_n, we_n, oe;
  logic [15:0] rdata, dq_out;
  logic [15:0] dq_in = 16'hBAD0;
  logic [1:0] ba, dqm;
  logic [12:0] a;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  vsdram_ctrl #(.INIT_CYCLES(INIT_CYC), .REF_INTERVAL(REF_INT)) u_vsdram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .bank_i(bank), .row_i(row),
    .col_i(col), .wdata_i(wdata), .wmask_i(wmask), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .rvalid_o(rvalid), .sd_cs_no(cs_n), .sd_ras_no(ras_n),
    .sd_cas_no(cas_n), .sd_we_no(we_n), .sd_ba_o(ba), .sd_a_o(a), .sd_dq_o(dq_out),
    .sd_dq_oe_o(oe), .sd_dqm_o(dqm), .sd_dq_i(dq_in)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int need_gap(input logic [3:0] c);
    case (c)
      4'b0010: return 2;
      4'b0001: return 6;
      4'b0000: return 4;
      4'b0011: return 2;
      4'b0100: return 5;
      4'b0101: return 6;
      default: return 0;
    endcase
  endfunction

  // memory model and protocol monitor
  logic [15:0] mem [256];
  logic [2:0]  open_row [4];
  logic [3:0]  c, last_c = 4'b0111;
  int edge_n = 0, rel_edge = 0, last_t = 0, act_t = -100, rd_t = -100, ref_t = 0;
  int init_step = 0, ref_cnt = 0;
  bit wr_p = 0;
  logic [7:0] rd_i0, rd_i1, wr_i1;

  task automatic mem_wr(input logic [7:0] idx);
    if (!dqm[1]) mem[idx][15:8] = dq_out[15:8];
    if (!dqm[0]) mem[idx][7:0]  = dq_out[7:0];
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int i = 0; i < 4; i++) open_row[i] = 3'd0;
  end

  always @(posedge clk) begin
    edge_n++;
    c = {cs_n, ras_n, cas_n, we_n};
    if (edge_n == rd_t + 1) dq_in <= mem[rd_i0];
    else if (edge_n == rd_t + 2) dq_in <= mem[rd_i1];
    else if (edge_n == rd_t + 3) dq_in <= 16'hBAD0;
    if (wr_p) begin
      chk(oe, "R5 beat1 drive enable", {31'd0, oe}, 32'd1);
      mem_wr(wr_i1);
      wr_p = 0;
    end
    if (rst_n && c != 4'b0111) begin
      if (last_c != 4'b0111)
        chk(edge_n - last_t >= need_gap(last_c), "R3 command gap",
            edge_n - last_t, need_gap(last_c));
      if (init_step < 4) begin
        case (init_step)
          0: begin
            chk(c == 4'b0010 && a[10], "R1 precharge all first", {c, a}, {4'b0010, 13'h400});
            chk(edge_n - rel_edge >= INIT_CYC, "R1 power-up wait", edge_n - rel_edge, INIT_CYC);
          end
          1, 2: chk(c == 4'b0001, "R1 init refresh", c, 4'b0001);
          default: chk(c == 4'b0000 && a == 13'h021 && !ready, "R1 mode load",
                       {ready, c, a}, {1'b0, 4'b0000, 13'h021});
        endcase
        init_step++;
        ref_t = edge_n;
      end else begin
        case (c)
          4'b0011: begin
            chk(edge_n - act_t >= 6, "R3 active to active", edge_n - act_t, 6);
            act_t = edge_n;
            open_row[ba] = a[2:0];
          end
          4'b0100, 4'b0101: begin
            chk(edge_n - act_t == 2, "R3 active to column", edge_n - act_t, 2);
            chk(a[10], "R4 auto precharge bit", {31'd0, a[10]}, 32'd1);
            if (c == 4'b0100) begin
              chk(oe, "R5 beat0 drive enable", {31'd0, oe}, 32'd1);
              mem_wr({ba, open_row[ba], a[2:0]});
              wr_i1 = {ba, open_row[ba], a[2:1], ~a[0]};
              wr_p = 1;
            end else begin
              rd_i0 = {ba, open_row[ba], a[2:0]};
              rd_i1 = {ba, open_row[ba], a[2:1], ~a[0]};
              rd_t = edge_n;
            end
          end
          4'b0001: begin
            chk(edge_n - ref_t <= REF_INT + 16, "R8 refresh interval", edge_n - ref_t, REF_INT + 16);
            ref_t = edge_n;
            ref_cnt++;
          end
          default: chk(0, "R2 unexpected command after init", c, 4'b0111);
        endcase
      end
      last_c = c;
      last_t = edge_n;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected below 100000", wd);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic burst(input logic [VW-1:0] v, output int beats, output logic [31:0] got);
    beats = 0; got = '0;
    we = v[76]; bank = v[75:74]; row = {10'd0, v[73:71]}; col = {6'd0, v[70:68]};
    wdata = v[67:36]; wmask = v[35:32]; req = 1'b1;
    forever begin
      @(negedge clk);
      if (rvalid) begin
        if (beats == 0) got[15:0] = rdata; else got[31:16] = rdata;
        beats++;
      end
      if (done) break;
    end
    req = 1'b0;
  endtask

  initial begin
    int beats;
    logic [31:0] got;
    int r0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2 reset command NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(!ready && !done && !rvalid && !oe, "R2 reset outputs low",
        {ready, done, rvalid, oe}, 4'b0000);
    rst_n = 1'b1;
    rel_edge = edge_n;
    // first request raised before ready (R2): must wait for init
    for (int i = 0; i < 8; i++) begin
      burst(VEC[i], beats, got);
      if (i == 0) chk(ready, "R1 ready after init", {31'd0, ready}, 32'd1);
      if (VEC[i][76]) chk(beats == 0, "R7 no read beats on write", beats, 0);
      else begin
        chk(beats == 2, "R7 two read beats", beats, 2);
        chk(got == VEC[i][31:0], (i == 5) ? "R5 masked bytes" : (i == 7) ? "R9 wrap order" : "R7 read data",
            got, VEC[i][31:0]);
      end
      @(negedge clk);
      chk(!done, "R6 done is one cycle", {31'd0, done}, 32'd0);
    end
    // back-to-back traffic keeps refresh alive
    for (int k = 0; k < 40; k++) begin
      burst(VEC[k % 8 == 0 ? 0 : 2], beats, got);
      if (k == 39) chk(got == 32'h5678_1234, "R8 data intact under refresh", got, 32'h5678_1234);
    end
    // idle window: refresh continues (R8)
    r0 = ref_cnt;
    repeat (5 * REF_INT) @(negedge clk);
    chk(ref_cnt - r0 >= 4, "R8 idle refreshes", ref_cnt - r0, 4);
    chk(init_step == 4, "R1 init sequence complete", init_step, 4);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule